// File: doc/BRIEF.md
# Signed Dot-Product Outer-Product Accumulator Tile

This block holds a square tile of accumulators (4 rows by 4 columns by default). Each operation takes two source vectors of sixteen signed lanes and one predicate per source. It adds to every tile element (i,j) the four-term dot product of lane group i of the first source with lane group j of the second source. A group is four consecutive lanes.

In the default narrow mode each lane is a signed byte and the accumulators behave as 32-bit values. In wide mode each lane is a signed halfword and the accumulators are full 64-bit values. The surrounding datapath starts an operation with a single-cycle request and waits for the completion strobe. It can zero the whole tile between jobs and read back one row of four elements at a time.

Control is a three-state machine:
- `ST_IDLE` accepts a start or a clear.
- `ST_ACCUM` updates one row per cycle, rows 0 to 3 in order.
- `ST_REPORT` raises the completion strobe for one cycle.

Transitions:
- `ST_IDLE` goes to `ST_ACCUM` when a start is accepted.
- `ST_ACCUM` goes to `ST_REPORT` after the last row.
- `ST_REPORT` always goes back to `ST_IDLE`.

Top module: `opa_tile`

## Requirements
- R1: In narrow mode, lane n of a source is the signed byte at bits [8n+7:8n]; bits 255:128 of both sources are ignored. Element (i,j) gains the sum over k=0..3 of a[4i+k]*b[4j+k].
- R2: Start from a zeroed tile. With first-source bytes 0..15 and second-source bytes 16..31, all lanes enabled, narrow mode: row 0 reads 110, 134, 158, 182 and row 3 reads 950, 1166, 1382, 1598.
- R3: The product a[4i+k]*b[4j+k] contributes only when bit 4i+k of `pred_a` and bit 4j+k of `pred_b` are both 1 (bit n belongs to lane n). Otherwise it counts as zero.
- R4: A narrow-mode operation keeps only the low 32 bits of each element, adding modulo 2^32. Bits 63:32 of the element then read as zero, so a negative result is not sign-extended.
- R5: With `wide_mode`=1 at start, lane n is the signed halfword at bits [16n+15:16n], and elements add modulo 2^64. Halfwords 0..15 and 16..31 on a zeroed tile give the same row values as R2.
- R6: Each operation adds to the tile's previous contents rather than overwriting them.
- R7: Zeroing the tile:
  - `clear` in `ST_IDLE` zeroes every element at the next edge.
  - A `clear` together with `start` wins, and that start is dropped.
  - `clear` while busy has no effect.
- R8: When `rd_en` is high at an edge, `rd_valid` is high during the next cycle. `rd_data` then holds the four elements of row `rd_row`, element j at bits [64j+63:64j], as they stood before that edge.
- R9: When a start is accepted at an edge, `busy` rises after that edge. `done` is high for exactly one cycle, the one after the fourth following edge. `busy` falls one edge later.
- R10: A `start` while `busy` is high is ignored: the tile, the operands in use and the completion timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one accumulate operation |
| wide_mode | input | 1 | 1 selects halfword lanes and 64-bit accumulation |
| src_a | input | 256 | First source vector (row operand) |
| src_b | input | 256 | Second source vector (column operand) |
| pred_a | input | 16 | Per-lane enable for the first source |
| pred_b | input | 16 | Per-lane enable for the second source |
| clear | input | 1 | Zero the tile when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_en | input | 1 | Row read request |
| rd_row | input | 2 | Row index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 256 | Four 64-bit elements of the selected row |

## Verification
Ascending byte and halfword ramps give fixed reference rows, which separate correct group indexing from swapped or transposed lanes. Repeating the same ramp tests accumulation against overwrite. Sparse, different predicates on the two sources show whether masking uses the correct lane on each side. Saturated negative operands (most negative value against most positive) expose sign handling and the narrow-mode truncation of bits 63:32. Requests injected while busy, and a clear arriving together with a start, show whether the machine guards its operands and follows the clear-over-start priority.

// File: rtl/opa_pkg.sv
package opa_pkg;
    localparam int OPA_TILE_N = 4;
    localparam int OPA_DOT_K  = 4;
    localparam int OPA_LANE_W = 16;
    localparam int OPA_ACC_W  = 64;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_REPORT = 2'd2
    } opa_state_e;
endpackage

// File: rtl/opa_dot_unit.sv
module opa_dot_unit #(
    parameter int DOT_K  = 4,
    parameter int LANE_W = 16,
    parameter int ACC_W  = 64
) (
    input  logic [DOT_K-1:0][LANE_W-1:0] a_grp,
    input  logic [DOT_K-1:0][LANE_W-1:0] b_grp,
    input  logic [DOT_K-1:0]             pa,
    input  logic [DOT_K-1:0]             pb,
    output logic [ACC_W-1:0]             sum
);
    localparam int PROD_W = 2 * LANE_W;

    logic [DOT_K-1:0][ACC_W-1:0] term;

    for (genvar k = 0; k < DOT_K; k++) begin : g_term
        logic signed [PROD_W-1:0] prod;
        assign prod = $signed(a_grp[k]) * $signed(b_grp[k]);
        assign term[k] = (pa[k] && pb[k])
                       ? {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod}
                       : '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < DOT_K; k++) begin
            sum = sum + term[k];
        end
    end
endmodule

// File: rtl/opa_row_unit.sv
module opa_row_unit #(
    parameter int TILE_N = 4,
    parameter int DOT_K  = 4,
    parameter int LANE_W = 16,
    parameter int ACC_W  = 64,
    localparam int LANES = TILE_N * DOT_K
) (
    input  logic [DOT_K-1:0][LANE_W-1:0] a_grp,
    input  logic [DOT_K-1:0]             pa_grp,
    input  logic [LANES-1:0][LANE_W-1:0] b_all,
    input  logic [LANES-1:0]             pb_all,
    output logic [TILE_N-1:0][ACC_W-1:0] row_sum
);
    for (genvar j = 0; j < TILE_N; j++) begin : g_col
        opa_dot_unit #(
            .DOT_K (DOT_K),
            .LANE_W(LANE_W),
            .ACC_W (ACC_W)
        ) u_dot (
            .a_grp(a_grp),
            .b_grp(b_all[j*DOT_K +: DOT_K]),
            .pa   (pa_grp),
            .pb   (pb_all[j*DOT_K +: DOT_K]),
            .sum  (row_sum[j])
        );
    end
endmodule

// File: rtl/opa_tile.sv
module opa_tile
    import opa_pkg::*;
#(
    parameter int TILE_N = OPA_TILE_N,
    parameter int DOT_K  = OPA_DOT_K,
    parameter int LANE_W = OPA_LANE_W,
    parameter int ACC_W  = OPA_ACC_W,
    localparam int LANES    = TILE_N * DOT_K,
    localparam int SRC_W    = LANES * LANE_W,
    localparam int BYTE_W   = LANE_W / 2,
    localparam int NARROW_W = ACC_W / 2,
    localparam int ROW_W    = $clog2(TILE_N),
    localparam int RD_W     = TILE_N * ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wide_mode,
    input  logic [SRC_W-1:0] src_a,
    input  logic [SRC_W-1:0] src_b,
    input  logic [LANES-1:0] pred_a,
    input  logic [LANES-1:0] pred_b,
    input  logic             clear,
    output logic             busy,
    output logic             done,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_valid,
    output logic [RD_W-1:0]  rd_data
);
    opa_state_e state_q, state_d;

    logic [LANES-1:0][LANE_W-1:0] lane_a, lane_b;
    logic [LANES-1:0][LANE_W-1:0] op_a_q, op_b_q;
    logic [LANES-1:0]             pa_q, pb_q;
    logic                         wide_q;
    logic [ROW_W-1:0]             row_q;
    logic [ACC_W-1:0]             tile_q [TILE_N][TILE_N];
    logic [TILE_N-1:0][ACC_W-1:0] row_sum;
    logic                         take_start, take_clear, acc_en;

    // Lane normalisation: both modes become signed LANE_W-bit operands
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign lane_a[n] = wide_mode ? src_a[n*LANE_W +: LANE_W]
                         : {{BYTE_W{src_a[n*BYTE_W+BYTE_W-1]}}, src_a[n*BYTE_W +: BYTE_W]};
        assign lane_b[n] = wide_mode ? src_b[n*LANE_W +: LANE_W]
                         : {{BYTE_W{src_b[n*BYTE_W+BYTE_W-1]}}, src_b[n*BYTE_W +: BYTE_W]};
    end

    assign take_clear = clear && (state_q == ST_IDLE);
    assign take_start = start && !clear && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_start) state_d = ST_ACCUM;
            ST_ACCUM:  if (row_q == ROW_W'(TILE_N - 1)) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        acc_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACCUM:  begin busy = 1'b1; acc_en = 1'b1; end
            ST_REPORT: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    opa_row_unit #(
        .TILE_N(TILE_N),
        .DOT_K (DOT_K),
        .LANE_W(LANE_W),
        .ACC_W (ACC_W)
    ) u_row (
        .a_grp  (op_a_q[row_q*DOT_K +: DOT_K]),
        .pa_grp (pa_q[row_q*DOT_K +: DOT_K]),
        .b_all  (op_b_q),
        .pb_all (pb_q),
        .row_sum(row_sum)
    );

    // Operand capture and row-serial accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a_q <= '0;
            op_b_q <= '0;
            pa_q   <= '0;
            pb_q   <= '0;
            wide_q <= 1'b0;
            row_q  <= '0;
            for (int i = 0; i < TILE_N; i++)
                for (int j = 0; j < TILE_N; j++)
                    tile_q[i][j] <= '0;
        end else begin
            if (take_start) begin
                op_a_q <= lane_a;
                op_b_q <= lane_b;
                pa_q   <= pred_a;
                pb_q   <= pred_b;
                wide_q <= wide_mode;
                row_q  <= '0;
            end
            if (acc_en) begin
                for (int j = 0; j < TILE_N; j++) begin
                    if (wide_q)
                        tile_q[row_q][j] <= tile_q[row_q][j] + row_sum[j];
                    else
                        tile_q[row_q][j] <= {{(ACC_W-NARROW_W){1'b0}},
                            tile_q[row_q][j][NARROW_W-1:0] + row_sum[j][NARROW_W-1:0]};
                end
                row_q <= row_q + 1'b1;
            end
            if (take_clear) begin
                for (int i = 0; i < TILE_N; i++)
                    for (int j = 0; j < TILE_N; j++)
                        tile_q[i][j] <= '0;
            end
        end
    end

    // Row read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                for (int j = 0; j < TILE_N; j++)
                    rd_data[j*ACC_W +: ACC_W] <= tile_q[rd_row][j];
            end
        end
    end

    // Assertions
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_last_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q) == ST_ACCUM) && ($past(row_q) == ROW_W'(TILE_N - 1)));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_a_q) && $stable(op_b_q) && $stable(wide_q));

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !busy) |=> !busy && (tile_q[0][0] == '0)
                             && (tile_q[TILE_N-1][TILE_N-1] == '0));

    assert_read_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: tb/sim_opa_tile.sv
module sim_opa_tile;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, wide_mode = 1'b0, clear = 1'b0, rd_en = 1'b0;
    logic [255:0] src_a = '0, src_b = '0;
    logic [15:0]  pred_a = '0, pred_b = '0;
    logic [1:0]   rd_row = '0;
    logic         busy, done, rd_valid;
    logic [255:0] rd_data;

    always #4 clk = ~clk;

    opa_tile u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .src_a(src_a), .src_b(src_b), .pred_a(pred_a), .pred_b(pred_b),
        .clear(clear), .busy(busy), .done(done), .rd_en(rd_en),
        .rd_row(rd_row), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int errors = 0;
    int checks = 0;
    bit ended  = 0;

    typedef struct {
        logic [255:0] exp;
        string        tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    logic [63:0] mdl [4][4];

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference: per-element dot products from the requirements
    task automatic model_apply(input logic [255:0] a, input logic [255:0] b,
                               input logic [15:0] pa, input logic [15:0] pb,
                               input bit wide);
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic signed [63:0] s;
                s = 0;
                for (int k = 0; k < 4; k++) begin
                    int la, lb;
                    logic signed [63:0] va, vb;
                    la = 4 * i + k;
                    lb = 4 * j + k;
                    va = wide ? 64'($signed(a[16*la +: 16])) : 64'($signed(a[8*la +: 8]));
                    vb = wide ? 64'($signed(b[16*lb +: 16])) : 64'($signed(b[8*lb +: 8]));
                    if (pa[la] && pb[lb]) s = s + va * vb;
                end
                if (wide) mdl[i][j] = mdl[i][j] + s;
                else      mdl[i][j] = {32'h0, mdl[i][j][31:0] + s[31:0]};
            end
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                mdl[i][j] = '0;
    endtask

    function automatic logic [255:0] model_row(input int r);
        return {mdl[r][3], mdl[r][2], mdl[r][1], mdl[r][0]};
    endfunction

    function automatic logic [255:0] ramp(input int base, input bit wide);
        logic [255:0] v;
        v = '0;
        for (int n = 0; n < 16; n++) begin
            if (wide) v[16*n +: 16] = 16'(base + n);
            else      v[8*n +: 8]   = 8'(base + n);
        end
        return v;
    endfunction

    function automatic logic [255:0] pack4(input logic [63:0] e0, input logic [63:0] e1,
                                           input logic [63:0] e2, input logic [63:0] e3);
        return {e3, e2, e1, e0};
    endfunction

    // Driver: issues a read and pushes the expected row into the scoreboard
    task automatic read_row(input int r, input logic [255:0] exp, input string tag);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_row = 2'(r);
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int r = 0; r < 4; r++) read_row(r, model_row(r), tag);
    endtask

    // Monitor: pops and compares as read results appear
    always @(negedge clk) begin
        if (rd_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected rd_valid", 256'(rd_valid), 256'(0));
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(rd_data === it.exp, it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model_clear();
    endtask

    // One operation with exact timing check; inject=1 drives start and clear while busy
    task automatic do_op(input logic [255:0] a, input logic [255:0] b,
                         input logic [15:0] pa, input logic [15:0] pb,
                         input bit wide, input bit inject);
        bit ok;
        @(negedge clk);
        src_a = a; src_b = b; pred_a = pa; pred_b = pb; wide_mode = wide;
        start = 1'b1;
        ok = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                start = 1'b0;
                src_a = ~a; src_b = ~b; pred_a = '1; pred_b = '1; wide_mode = ~wide;
            end
            if (inject && i == 2) begin start = 1'b1; clear = 1'b1; end
            if (inject && i == 4) begin start = 1'b0; clear = 1'b0; end
            if (i <= 5 && (busy !== 1'b1)) ok = 1'b0;
            if (done !== (i == 5)) ok = 1'b0;
            if (i == 6 && busy !== 1'b0) ok = 1'b0;
        end
        start = 1'b0; clear = 1'b0;
        check(ok, inject ? "R10 timing with start/clear while busy" : "R9 busy/done timing",
              256'(ok), 256'(1));
        model_apply(a, b, pa, pb, wide);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R9 reset state",
              {busy, done, rd_valid}, 256'(0));
        read_all("R8 reset tile reads zero");
        drain();

        // R1/R2: narrow ramp, junk in ignored upper bits
        begin
            logic [255:0] a, b;
            a = ramp(0, 0);  a[255:128] = {4{32'hDEAD_BEEF}};
            b = ramp(16, 0); b[255:128] = {4{32'h1234_5678}};
            do_op(a, b, '1, '1, 0, 0);
            read_row(0, pack4(110, 134, 158, 182), "R2 row 0 of ramp");
            read_row(3, pack4(950, 1166, 1382, 1598), "R2 row 3 of ramp");
            read_row(1, model_row(1), "R1 row 1 of ramp");
            read_row(2, model_row(2), "R1 row 2 of ramp");
            drain();
            // R6: same operation again accumulates
            do_op(a, b, '1, '1, 0, 0);
            read_row(0, pack4(220, 268, 316, 364), "R6 row 0 doubled");
            read_all("R6 accumulate onto previous");
            drain();
        end

        // R7: clear in idle
        do_clear();
        read_all("R7 clear zeroes tile");
        drain();

        // R3: dual predication with mixed-sign data
        begin
            logic [255:0] a, b;
            a = '0; b = '0;
            for (int n = 0; n < 16; n++) begin
                a[8*n +: 8] = 8'(n * 37 - 90);
                b[8*n +: 8] = 8'(113 - n * 29);
            end
            do_op(a, b, 16'h0F3C, 16'hA5F0, 0, 0);
            read_all("R3 predicated lanes");
            drain();
        end

        // R4: negative narrow result, upper 32 bits zero
        do_clear();
        do_op({16{8'h80}}, {16{8'h7F}}, '1, '1, 0, 0);
        read_row(2, pack4(64'h0000_0000_FFFF_0200, 64'h0000_0000_FFFF_0200,
                          64'h0000_0000_FFFF_0200, 64'h0000_0000_FFFF_0200),
                 "R4 narrow negative truncates to 32 bits");
        drain();

        // R5: wide ramp gives same rows, wide negative sign-extends
        do_clear();
        do_op(ramp(0, 1), ramp(16, 1), '1, '1, 1, 0);
        read_row(0, pack4(110, 134, 158, 182), "R5 wide row 0");
        read_row(3, pack4(950, 1166, 1382, 1598), "R5 wide row 3");
        drain();
        do_clear();
        do_op({16{16'h8000}}, {16{16'h7FFF}}, '1, '1, 1, 0);
        read_row(1, {4{64'hFFFF_FFFF_0002_0000}}, "R5 wide negative full 64 bits");
        drain();
        // R4: narrow op after wide tile drops upper half
        do_op(ramp(3, 0), ramp(-7, 0), 16'hFFFF, 16'h7FFE, 0, 0);
        read_all("R4 narrow after wide keeps low 32 bits");
        drain();

        // R10 and R7: start and clear while busy are ignored
        do_op(ramp(-20, 0), ramp(5, 0), 16'hF0F0, 16'hFFFF, 0, 1);
        read_all("R10 R7 requests while busy ignored");
        drain();

        // R7: clear with start in same cycle, clear wins
        @(negedge clk);
        src_a = ramp(1, 0); src_b = ramp(1, 0); pred_a = '1; pred_b = '1;
        clear = 1'b1; start = 1'b1;
        @(negedge clk);
        clear = 1'b0; start = 1'b0;
        model_clear();
        check(busy === 1'b0, "R7 start dropped when clear present", 256'(busy), 256'(0));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R7 no operation after clear+start",
              {busy, done}, 256'(0));
        read_all("R7 clear wins over start");
        drain();

        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule